// File: doc/BRIEF.md
# Final-Level Page Table Walker

This block finishes a 4-level, 64-bit address translation. The directory-level entry has already been chosen by the earlier levels. It arrives with the low 21 bits of the linear address and four access attributes: write, user mode, instruction fetch and the no-execute enable. The block first checks that directory entry. If the entry maps a 2 MB page, the result comes from the entry at once. If it points to a page table, the block issues one 64-bit memory read for the leaf entry, checks that entry, and produces the 4 KB physical address.

Each walk ends with a one-cycle completion pulse. The pulse carries a 52-bit physical address, a fault flag and a 3-bit cause code. Cause codes are: 0 = none, 1 = entry not present, 2 = reserved bit set, 3 = write refused, 4 = user access refused, 5 = fetch refused. A new walk is accepted only when the block is idle. The memory port has a request/ready handshake and a separate response-valid strobe, with one read outstanding at most.

Top module: `pte_leaf_walker`

## Requirements
- R1: After reset, `done_o`, `rd_req_o` and `fault_o` are low and `cause_o` is 0.
- R2: If directory-entry bit 0 (present) is 0, the walk ends with cause 1, no memory read is issued, and the physical address is zero.
- R3: A directory entry with any bit in 51 down to PA_W set, or with bit 63 set while no-execute is disabled, ends with cause 2 and no read. This reserved-bit fault outranks any permission fault in the same entry.
- R4: For a directory entry with bit 7 clear, the read address is {entry[51:12], lin[20:12], 3'b000}. `rd_req_o` and `rd_addr_o` are held steady until `rd_ready_i` is seen.
- R5: A successful 4 KB walk returns {leaf[51:12], lin[11:0]}.
- R6: If directory-entry bit 7 (page size) is 1, no read is issued. A fault-free walk returns {entry[51:21], lin[20:0]}, and permissions come from the directory entry alone.
- R7: Effective write and user rights are the AND of bit 1 and of bit 2 over both levels. Execute-disable is the OR of bit 63 over both levels. A write without write right gives cause 3. A user access without user right gives cause 4. A fetch with execute-disable set while no-execute is enabled gives cause 5. When several apply, the priority is 3, then 4, then 5.
- R8: The fetched leaf entry gets the same present check (cause 1) and reserved-bit check (cause 2) as the directory entry.
- R9: Bits 6, 11:8 and 62:52 of the directory entry do not change the result.
- R10: `done_o` is high for exactly one cycle per walk. `fault_o` is high exactly when `cause_o` is nonzero. On a fault, `pa_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a walk (taken when idle) |
| pde_i | input | 64 | Directory-level entry |
| lin_i | input | 21 | Linear address bits 20:0 |
| is_write_i | input | 1 | Access is a write |
| is_user_i | input | 1 | Access is from user mode |
| is_fetch_i | input | 1 | Access is an instruction fetch |
| nx_en_i | input | 1 | No-execute enable |
| rd_req_o | output | 1 | Leaf-entry read request |
| rd_addr_o | output | 52 | Leaf-entry read address |
| rd_ready_i | input | 1 | Memory accepts request |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Read data (leaf entry) |
| done_o | output | 1 | Walk complete pulse |
| pa_o | output | 52 | Physical address |
| fault_o | output | 1 | Walk faulted |
| cause_o | output | 3 | Fault cause code |

## Verification
A reserved-bit fault and a permission fault can both be found in the same check cycle, because one entry can carry a reserved bit and also deny the access. The bench provokes this with a directory entry that has a reserved bit set and read/write clear, walked as a write. It also uses an entry with bit 63 set while no-execute is off, walked as a fetch. In both cases the expected cause is 2 and not 3 or 5. Write, user and fetch refusals also land in the same cycle. The bench raises write and user denial together and expects cause 3.

// File: rtl/pte_leaf_walker.sv
module pte_leaf_walker #(
  parameter int PA_W = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [63:0] pde_i,
  input  logic [20:0] lin_i,
  input  logic        is_write_i,
  input  logic        is_user_i,
  input  logic        is_fetch_i,
  input  logic        nx_en_i,
  output logic        rd_req_o,
  output logic [51:0] rd_addr_o,
  input  logic        rd_ready_i,
  input  logic        rd_rsp_valid_i,
  input  logic [63:0] rd_data_i,
  output logic        done_o,
  output logic [51:0] pa_o,
  output logic        fault_o,
  output logic [2:0]  cause_o
);
  localparam logic [63:0] RSV_MASK = {12'h000, {(52-PA_W){1'b1}}, {PA_W{1'b0}}};
  localparam logic [2:0] C_NONE = 3'd0, C_NP = 3'd1, C_RSV = 3'd2,
                         C_WR = 3'd3, C_US = 3'd4, C_XD = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_CHK_PDE, S_FETCH, S_WAIT, S_CHK_PTE, S_DONE} st_t;
  st_t st;

  logic [63:0] pde_q, pte_q, ent;
  logic [20:0] lin_q;
  logic wr_q, us_q, fe_q, nx_q;
  logic rw_eff, us_eff, xd_eff, rsv_hit, leaf;
  logic [2:0] chk_cause;
  logic [51:0] pa_val;

  assign leaf    = (st == S_CHK_PTE);
  assign ent     = leaf ? pte_q : pde_q;
  assign rw_eff  = pde_q[1] & (leaf ? pte_q[1] : 1'b1);
  assign us_eff  = pde_q[2] & (leaf ? pte_q[2] : 1'b1);
  assign xd_eff  = pde_q[63] | (leaf & pte_q[63]);
  assign rsv_hit = (|(ent & RSV_MASK)) | (~nx_q & ent[63]);
  assign pa_val  = leaf ? {pte_q[51:12], lin_q[11:0]} : {pde_q[51:21], lin_q};

  always_comb begin
    if (!ent[0])                          chk_cause = C_NP;
    else if (rsv_hit)                     chk_cause = C_RSV;
    else if (wr_q && !rw_eff)             chk_cause = C_WR;
    else if (us_q && !us_eff)             chk_cause = C_US;
    else if (fe_q && nx_q && xd_eff)      chk_cause = C_XD;
    else                                  chk_cause = C_NONE;
  end

  assign rd_req_o  = (st == S_FETCH);
  assign rd_addr_o = {pde_q[51:12], lin_q[20:12], 3'b000};
  assign done_o    = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pde_q   <= '0;
      pte_q   <= '0;
      lin_q   <= '0;
      wr_q    <= 1'b0;
      us_q    <= 1'b0;
      fe_q    <= 1'b0;
      nx_q    <= 1'b0;
      pa_o    <= '0;
      fault_o <= 1'b0;
      cause_o <= C_NONE;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          pde_q <= pde_i;
          lin_q <= lin_i;
          wr_q  <= is_write_i;
          us_q  <= is_user_i;
          fe_q  <= is_fetch_i;
          nx_q  <= nx_en_i;
          st    <= S_CHK_PDE;
        end
        S_CHK_PDE: begin
          if (chk_cause == C_NP || chk_cause == C_RSV || pde_q[7]) begin
            fault_o <= (chk_cause != C_NONE);
            cause_o <= chk_cause;
            pa_o    <= (chk_cause != C_NONE) ? '0 : pa_val;
            st      <= S_DONE;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (rd_ready_i) st <= S_WAIT;
        S_WAIT: if (rd_rsp_valid_i) begin
          pte_q <= rd_data_i;
          st    <= S_CHK_PTE;
        end
        S_CHK_PTE: begin
          fault_o <= (chk_cause != C_NONE);
          cause_o <= chk_cause;
          pa_o    <= (chk_cause != C_NONE) ? '0 : pa_val;
          st      <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fault_o == (cause_o != C_NONE)));
  a_r10_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o) |-> (pa_o == '0));
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));
  a_r2_np_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK_PDE && !pde_q[0]) |=> (done_o && !rd_req_o && cause_o == C_NP));
  a_r6_large_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK_PDE && pde_q[0] && pde_q[7]) |=> (done_o && !rd_req_o));
endmodule

// File: tb/pte_leaf_walker_bench.sv
module pte_leaf_walker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [63:0] pde_i = '0;
  logic [20:0] lin_i = '0;
  logic is_write_i = 1'b0, is_user_i = 1'b0, is_fetch_i = 1'b0, nx_en_i = 1'b0;
  logic rd_req_o, rd_ready_i = 1'b0, rd_rsp_valid_i = 1'b0;
  logic [51:0] rd_addr_o, pa_o;
  logic [63:0] rd_data_i = '0;
  logic done_o, fault_o;
  logic [2:0] cause_o;

  int total = 0, bad = 0;
  int reads = 0, ready_dly = 0;
  logic [51:0] first_addr, acc_addr;
  logic [63:0] mem_word = '0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  pte_leaf_walker u_pte_leaf_walker (
    .clk, .rst_n, .start_i, .pde_i, .lin_i, .is_write_i, .is_user_i,
    .is_fetch_i, .nx_en_i, .rd_req_o, .rd_addr_o, .rd_ready_i,
    .rd_rsp_valid_i, .rd_data_i, .done_o, .pa_o, .fault_o, .cause_o);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : mem_model
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        first_addr = rd_addr_o;
        for (int i = 0; i < ready_dly; i++) @(negedge clk);
        acc_addr = rd_addr_o;
        rd_ready_i = 1'b1;
        reads++;
        @(negedge clk);
        rd_ready_i = 1'b0;
        @(negedge clk);
        rd_data_i = mem_word;
        rd_rsp_valid_i = 1'b1;
        @(negedge clk);
        rd_rsp_valid_i = 1'b0;
        rd_data_i = '0;
      end
    end
  end

  task automatic walk(input string tag, input logic [63:0] pde, input logic [20:0] lin,
                      input logic w, input logic u, input logic f, input logic nx,
                      input logic [63:0] pte, input logic [2:0] exp_cause,
                      input logic [51:0] exp_pa, input int exp_reads);
    int r0 = reads;
    int n = 0;
    mem_word = pte;
    @(negedge clk);
    pde_i = pde; lin_i = lin; is_write_i = w; is_user_i = u; is_fetch_i = f; nx_en_i = nx;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 60) begin
      @(negedge clk);
      n++;
    end
    check({tag, " done seen"}, {63'd0, done_o}, 64'd1);
    check({tag, " cause"}, {61'd0, cause_o}, {61'd0, exp_cause});
    check({tag, " fault"}, {63'd0, fault_o}, {63'd0, exp_cause != 3'd0});
    check({tag, " pa"}, {12'd0, pa_o}, {12'd0, exp_pa});
    check({tag, " reads"}, 64'(reads - r0), 64'(exp_reads));
    @(negedge clk);
    check({tag, " R10 pulse"}, {63'd0, done_o}, 64'd0);
  endtask

  localparam logic [63:0] PDE_OK = 64'h0000_00AB_CDE0_0007;
  localparam logic [63:0] PTE_OK = 64'h0000_0012_3456_7007;
  localparam logic [20:0] LIN    = 21'h1A_5C3E;

  task automatic t_reset();
    check("R1 done", {63'd0, done_o}, 64'd0);
    check("R1 req", {63'd0, rd_req_o}, 64'd0);
    check("R1 fault", {63'd0, fault_o}, 64'd0);
    check("R1 cause", {61'd0, cause_o}, 64'd0);
  endtask

  task automatic t_small_page();
    ready_dly = 3;
    walk("R5 4k", PDE_OK, LIN, 1, 1, 1, 1, PTE_OK, 3'd0, {PTE_OK[51:12], LIN[11:0]}, 1);
    check("R4 addr first", {12'd0, first_addr}, {12'd0, PDE_OK[51:12], LIN[20:12], 3'b000});
    check("R4 addr held", {12'd0, acc_addr}, {12'd0, PDE_OK[51:12], LIN[20:12], 3'b000});
    ready_dly = 0;
    walk("R5 4k b", PDE_OK, 21'h0F_FFFF, 0, 0, 0, 0, 64'h0000_00FF_FFFF_F001, 3'd0,
         {40'hFF_FFFF_F, 12'hFFF}, 1);
  endtask

  task automatic t_ignored();
    walk("R9 ignored", PDE_OK | 64'h7FF0_0000_0000_0F40, LIN, 1, 1, 0, 1, PTE_OK, 3'd0,
         {PTE_OK[51:12], LIN[11:0]}, 1);
    check("R9 addr", {12'd0, acc_addr}, {12'd0, PDE_OK[51:12], LIN[20:12], 3'b000});
  endtask

  task automatic t_large();
    logic [63:0] p = PDE_OK | 64'h80;
    walk("R6 large", p, LIN, 1, 1, 0, 1, PTE_OK, 3'd0, {p[51:21], LIN}, 0);
    walk("R6 large wr denied", p & ~64'h2, LIN, 1, 0, 0, 1, PTE_OK, 3'd3, '0, 0);
  endtask

  task automatic t_faults_pde();
    walk("R2 not present", PDE_OK & ~64'h1, LIN, 0, 0, 0, 0, PTE_OK, 3'd1, '0, 0);
    walk("R3 rsv bit45", PDE_OK | (64'd1 << 45), LIN, 0, 0, 0, 1, PTE_OK, 3'd2, '0, 0);
    walk("R3 bit63 nx off", PDE_OK | (64'd1 << 63), LIN, 0, 0, 1, 0, PTE_OK, 3'd2, '0, 0);
    walk("R3 rsv beats write", (PDE_OK | (64'd1 << 50)) & ~64'h2, LIN, 1, 0, 0, 1, PTE_OK,
         3'd2, '0, 0);
    walk("R7 xd no fetch ok", PDE_OK | (64'd1 << 63), LIN, 0, 0, 0, 1, PTE_OK, 3'd0,
         {PTE_OK[51:12], LIN[11:0]}, 1);
  endtask

  task automatic t_perms();
    walk("R7 pte ro write", PDE_OK, LIN, 1, 0, 0, 1, PTE_OK & ~64'h2, 3'd3, '0, 1);
    walk("R7 pde super user", PDE_OK & ~64'h4, LIN, 0, 1, 0, 1, PTE_OK, 3'd4, '0, 1);
    walk("R7 pte xd fetch", PDE_OK, LIN, 0, 0, 1, 1, PTE_OK | (64'd1 << 63), 3'd5, '0, 1);
    walk("R7 wr beats user", PDE_OK & ~64'h6, LIN, 1, 1, 0, 1, PTE_OK, 3'd3, '0, 1);
    walk("R7 user beats xd", PDE_OK | (64'd1 << 63), LIN, 0, 1, 1, 1, PTE_OK & ~64'h4,
         3'd4, '0, 1);
  endtask

  task automatic t_pte_checks();
    walk("R8 pte not present", PDE_OK, LIN, 0, 0, 0, 1, PTE_OK & ~64'h1, 3'd1, '0, 1);
    walk("R8 pte rsv", PDE_OK, LIN, 0, 0, 0, 1, PTE_OK | (64'd1 << 40), 3'd2, '0, 1);
    walk("R8 pte bit63 nx off", PDE_OK, LIN, 0, 0, 0, 0, PTE_OK | (64'd1 << 63), 3'd2, '0, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_page();
    t_ignored();
    t_large();
    t_faults_pde();
    t_perms();
    t_pte_checks();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule